// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital side of a 10-bit successive approximation converter. It advances only on clocks where the machine-cycle enable is high. A start request that arrives while the block is idle begins a fixed conversion of 50 machine cycles. The first two cycles initialise the converter. The next eight sample the analog input. The remaining forty resolve the code one bit per four machine cycles, working from the most significant bit down to the least significant bit.

The block drives the trial code to an external DAC and reads back one comparator bit, which is high when the input lies above the DAC level. It shows when the sampling window is open and raises a busy flag while a conversion is in flight. At the end it pulses a done strobe and stores the final code in a result register, with an 8-bit view of that register for coarse use. An abort input, used when entering a low-power mode, drops a conversion in flight and keeps the stored result.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion is accepted only on a clock where `start_i` and `mc_en_i` are both high, the block is idle and `abort_i` is low. A start request under any other condition has no effect on busy, done or the result.
- R2: `busy_o` rises at the end of the first machine cycle after acceptance. It then stays high until the done strobe.
- R3: `sample_o` is high for exactly the 8 machine cycles that follow the 2 initialisation cycles, and it is low at all other times.
- R4: When bit testing starts, the trial code is 10'b10_0000_0000, which is the most significant bit alone.
- R5: The comparator is sampled only on the enabled edge that ends the last machine cycle of each 4-cycle bit slot. If it is high, the bit under test stays set, and if it is low, that bit is cleared. The next lower bit is then set as the new trial.
- R6: The ten bits are tested from bit 9 down to bit 0, and each bit takes 4 machine cycles.
- R7: `done_o` is high for exactly one clock, at the end of the 50th machine cycle after acceptance. `busy_o` clears on the same edge.
- R8: `result_o` changes only when the done strobe fires. With a comparator that reports input value v > trial code, the stored result is v-1, or 0 when v is 0.
- R9: `result8_o` equals `result_o[9:2]`.
- R10: `abort_i` high on any clock edge ends a conversion in flight, whatever the state of `mc_en_i`. Busy clears, no done strobe follows, and the stored result is kept.
- R11: While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable, one clock per machine cycle |
| start_i | input | 1 | Start request |
| abort_i | input | 1 | Abort of a conversion in flight |
| cmp_above_i | input | 1 | Comparator: input above DAC level |
| trial_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sampling window open |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock completion strobe |
| result_o | output | 10 | Last completed code |
| result8_o | output | 8 | Upper 8 bits of the result |

## Verification
The assertions watch the rules that hold on every clock. Sampling happens only while busy, busy rises only on an enabled edge, the first trial is the lone MSB, and done lasts a single clock. The result never changes without a done strobe, an abort leaves neither busy nor done set, and the bit pointer stays in range. The absolute timing of busy, the sampling window and done, counted from the start, is shown only by the bench's scenarios. So are the final codes for chosen inputs, the point inside each slot where the comparator is sampled, and the effect of starts and aborts at particular points.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_SAMP = 2'd2,
    PH_CONV = 2'd3
  } sar_phase_e;
endpackage

// File: rtl/sar_timer.sv
module sar_timer
  import sar_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int INIT_MC    = 2,
  parameter int SAMP_MC    = 8,
  parameter int MC_PER_BIT = 4,
  localparam int PTR_W     = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mc_en_i,
  input  logic             start_i,
  input  logic             abort_i,
  output sar_phase_e       phase_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             accept_o,
  output logic             conv_go_o,
  output logic             decide_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_MAX0 = (INIT_MC > SAMP_MC) ? INIT_MC : SAMP_MC;
  localparam int CNT_MAX  = (CNT_MAX0 > MC_PER_BIT) ? CNT_MAX0 : MC_PER_BIT;
  localparam int CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_MC - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_MC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(MC_PER_BIT - 1);
  localparam logic [PTR_W-1:0] PTR_TOP   = PTR_W'(RES_W - 1);

  sar_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic             busy_q, done_q;

  assign accept_o  = (phase_q == PH_IDLE) && start_i && mc_en_i && !abort_i;
  assign conv_go_o = (phase_q == PH_SAMP) && mc_en_i && (cnt_q == SAMP_LAST) && !abort_i;
  assign decide_o  = (phase_q == PH_CONV) && mc_en_i && (cnt_q == BIT_LAST) && !abort_i;
  assign finish_o  = decide_o && (ptr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        busy_q  <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_IDLE: if (accept_o) begin
            phase_q <= PH_INIT;
            cnt_q   <= '0;
          end
          PH_INIT: if (mc_en_i) begin
            if (cnt_q == '0) busy_q <= 1'b1;
            if (cnt_q == INIT_LAST) begin
              phase_q <= PH_SAMP;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_SAMP: if (mc_en_i) begin
            if (cnt_q == SAMP_LAST) begin
              phase_q <= PH_CONV;
              cnt_q   <= '0;
              ptr_q   <= PTR_TOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_CONV: if (mc_en_i) begin
            if (cnt_q == BIT_LAST) begin
              cnt_q <= '0;
              if (ptr_q == '0) begin
                phase_q <= PH_IDLE;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
              end else ptr_q <= ptr_q - 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !done_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_mc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mc_en_i));
  p_ptr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CONV) |-> (int'(ptr_q) < RES_W));
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_W  = 10,
  localparam int PTR_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             accept_i,
  input  logic             conv_go_i,
  input  logic             decide_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             cmp_above_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] code_dec_o
);
  localparam logic [RES_W-1:0] FIRST = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, code_dec;

  // keep or drop bit under test, then arm the next lower bit
  always_comb begin
    code_dec = code_q;
    if (!cmp_above_i) code_dec[ptr_i] = 1'b0;
    if (ptr_i != '0) code_dec[ptr_i - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   code_q <= '0;
    else if (abort_i || accept_i)  code_q <= '0;
    else if (conv_go_i)            code_q <= FIRST;
    else if (decide_i)             code_q <= code_dec;
  end

  assign trial_o    = code_q;
  assign code_dec_o = code_dec;
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] code_i,
  output logic [RES_W-1:0] result_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_o <= '0;
    else if (load_i) result_o <= code_i;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int INIT_MC    = 2,
  parameter int SAMP_MC    = 8,
  parameter int MC_PER_BIT = 4,
  parameter int COARSE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mc_en_i,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic                cmp_above_i,
  output logic [RES_W-1:0]    trial_o,
  output logic                sample_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_W-1:0]    result_o,
  output logic [COARSE_W-1:0] result8_o
);
  localparam int PTR_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] FIRST = {1'b1, {(RES_W-1){1'b0}}};

  sar_phase_e       phase;
  logic [PTR_W-1:0] ptr;
  logic             accept, conv_go, decide, finish;
  logic [RES_W-1:0] code_dec;

  sar_timer #(
    .RES_W(RES_W), .INIT_MC(INIT_MC), .SAMP_MC(SAMP_MC), .MC_PER_BIT(MC_PER_BIT)
  ) u_timer (
    .clk_i, .rst_ni, .mc_en_i, .start_i, .abort_i,
    .phase_o(phase), .ptr_o(ptr), .accept_o(accept), .conv_go_o(conv_go),
    .decide_o(decide), .finish_o(finish), .busy_o(busy_o), .done_o(done_o)
  );

  sar_reg #(.RES_W(RES_W)) u_reg (
    .clk_i, .rst_ni, .abort_i, .accept_i(accept), .conv_go_i(conv_go),
    .decide_i(decide), .ptr_i(ptr), .cmp_above_i,
    .trial_o(trial_o), .code_dec_o(code_dec)
  );

  sar_result #(.RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .load_i(finish), .code_i(code_dec), .result_o(result_o)
  );

  assign sample_o  = (phase == PH_SAMP);
  assign result8_o = result_o[RES_W-1 -: COARSE_W];

  p_sample_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o);
  p_first_trial_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase == PH_CONV) |-> (trial_o == FIRST));
  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != $past(result_o)) |-> done_o);
endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mc_en_i = 1'b0;
  logic [1:0] div = 2'd0;
  logic       start_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       cmp_above_i;
  logic [9:0] trial_o, result_o;
  logic [7:0] result8_o;
  logic       sample_o, busy_o, done_o;
  int         vin = 0;
  int         force_md = 0;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    div     <= div + 2'd1;
    mc_en_i <= (div == 2'd2);
  end

  assign cmp_above_i = (force_md == 1) ? 1'b0 :
                       (force_md == 2) ? 1'b1 : (vin > int'(trial_o));

  sar_conv_seq dut (
    .clk_i, .rst_ni, .mc_en_i, .start_i, .abort_i, .cmp_above_i,
    .trial_o, .sample_o, .busy_o, .done_o, .result_o, .result8_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance past the next enabled edge, optionally requesting a start on it
  task automatic next_mc(input bit st);
    while (!mc_en_i) @(negedge clk_i);
    start_i = st;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic go_start();
    @(negedge clk_i);
    next_mc(1'b1);
  endtask

  function automatic int expect_code(input int v);
    return (v == 0) ? 0 : ((v > 1023) ? 1023 : v - 1);
  endfunction

  // full conversion; poke_n >= 0 issues an extra start on that edge
  task automatic run_conv(input int v, input int poke_n, input bit full);
    bit early_done = 1'b0;
    vin = v;
    go_start();
    if (full) chk(busy_o == 1'b0, "R2 busy low in first init cycle", busy_o, 0);
    for (int n = 1; n <= 50; n++) begin
      next_mc(n == poke_n);
      if (n < 50 && done_o) early_done = 1'b1;
      if (full) begin
        if (n == 1)  chk(busy_o == 1'b1 && sample_o == 1'b0, "R2 busy after first init cycle", busy_o, 1);
        if (n == 2)  chk(sample_o == 1'b1, "R3 sample opens", sample_o, 1);
        if (n == 9)  chk(sample_o == 1'b1, "R3 sample still open", sample_o, 1);
        if (n == 10) chk(sample_o == 1'b0, "R3 sample closes after 8", sample_o, 0);
        if (n == 10) chk(trial_o == 10'h200, "R4 first trial", trial_o, 'h200);
        if (n == 13) chk(trial_o == 10'h200, "R6 bit 9 slot lasts 4", trial_o, 'h200);
        if (n == 49) chk(busy_o == 1'b1, "R2 busy held to end", busy_o, 1);
      end
    end
    chk(!early_done, "R7 no early done", early_done, 0);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done at cycle 50", {busy_o, done_o}, 1);
    chk(int'(result_o) == expect_code(v), "R8 result", result_o, expect_code(v));
    chk(int'(result8_o) == (expect_code(v) >> 2), "R9 coarse result", result8_o, expect_code(v) >> 2);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done one clock", done_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && sample_o == 0 && trial_o == 0 && result_o == 0,
        "R11 reset outputs", {busy_o, done_o, sample_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && result8_o == 0, "R11 idle after reset", busy_o, 0);
  endtask

  task automatic t_values();
    run_conv(700, -1, 1'b1);
    run_conv(0, -1, 1'b0);
    run_conv(1, -1, 1'b0);
    run_conv(512, -1, 1'b0);
    run_conv(513, -1, 1'b0);
    run_conv(1024, -1, 1'b0);
    run_conv(341, -1, 1'b0);
  endtask

  task automatic t_restart_ignored();
    run_conv(258, 15, 1'b0); // R1 start mid-conversion ignored
    repeat (3) next_mc(1'b0);
    chk(busy_o == 1'b0, "R1 no restart after extra start", busy_o, 0);
  endtask

  task automatic t_start_no_en();
    @(negedge clk_i);
    while (mc_en_i) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) next_mc(1'b0);
    chk(busy_o == 1'b0, "R1 start without enable ignored", busy_o, 0);
  endtask

  task automatic t_decision_point();
    // R5 comparator only seen on the edge ending the 4th cycle of the slot
    vin = 0;
    go_start();
    for (int n = 1; n <= 13; n++) next_mc(1'b0);
    force_md = 2;
    next_mc(1'b0);
    force_md = 0;
    chk(trial_o == 10'h300, "R5 kept bit 9, armed bit 8", trial_o, 'h300);
    for (int n = 15; n <= 50; n++) next_mc(1'b0);
    chk(result_o == 10'h200, "R5 force high at decision", result_o, 'h200);
    vin = 1024;
    go_start();
    force_md = 2;
    for (int n = 1; n <= 13; n++) next_mc(1'b0);
    force_md = 1;
    next_mc(1'b0);
    force_md = 0;
    for (int n = 15; n <= 50; n++) next_mc(1'b0);
    chk(result_o == 10'h1FF, "R5 force low at decision", result_o, 'h1FF);
  endtask

  task automatic t_abort();
    bit seen = 1'b0;
    logic [9:0] prev = result_o;
    vin = 900;
    go_start();
    for (int n = 1; n <= 20; n++) next_mc(1'b0);
    @(negedge clk_i);
    while (mc_en_i) @(negedge clk_i);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    chk(busy_o == 1'b0, "R10 abort clears busy", busy_o, 0);
    for (int n = 0; n < 40; n++) begin
      next_mc(1'b0);
      if (done_o) seen = 1'b1;
    end
    chk(!seen, "R10 no done after abort", seen, 0);
    chk(result_o == prev, "R10 result kept", result_o, prev);
    run_conv(900, -1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_values();
    t_restart_ignored();
    t_start_no_en();
    t_decision_point();
    t_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule